// File: doc/BRIEF.md
# Lockable One-Time Security Identifier Register

This block holds a 128-bit identifier made of two 64-bit halves. The lower half is a fixed value set at build time through a parameter, and nothing can ever change it. The upper half starts blank, with every bit at one. User code can program it one 16-bit word at a time and can then lock it for good by clearing one bit of a separate lock word. Programming can only clear bits. The stored value becomes the old value ANDed with the new data, so a cleared bit cannot be set back to one.

A command sequencer issues a program operation with a one-cycle strobe, a word address and 16 bits of data. The block stays busy for a fixed, parameterized number of cycles. It then pulses done and reports two flags: a program-error flag and a lock-error flag. Identifier-mode reads use a separate combinational port indexed by word address. Words 0 to 3 hold the fixed half, with word 0 being the least significant. Words 4 to 7 hold the user half, and word 8 is the lock word.

Top module: `idreg_otp`

## Requirements
- R1: After reset, busy, done, pgmErr and lockErr are 0, user words 4..7 read 16'hFFFF and the lock word (address 8) reads 16'hFFFF.
- R2: A read of word address i in 0..3 returns bits [16*i+15:16*i] of the FACTORY_ID parameter.
- R3: A program operation to address 4..7 on an unlocked segment stores old AND data in that word and changes no other word.
- R4: An accepted strobe raises busy for exactly BUSY_CYCLES cycles. done then pulses high for exactly one cycle, in the cycle right after busy falls.
- R5: A strobe that arrives while busy is ignored and changes no word. It produces no extra done pulse.
- R6: A program address in 9..15 completes with pgmErr=1 and lockErr=0 and changes no word.
- R7: A program address in 0..3 completes with pgmErr=1 and lockErr=1 and leaves the fixed words unchanged.
- R8: Clearing bit 1 of the lock word (address 8) locks the user segment. From then on, a program operation to addresses 4..7 completes with pgmErr=1 and lockErr=1 and changes nothing. The lock can never be undone.
- R9: The lock word is programmed with the same AND rule whether or not the segment is locked. A successful operation reports pgmErr=0 and lockErr=0.
- R10: The flags are updated together with the done pulse and keep their values until the next strobe is accepted, which clears them.
- R11: Reads of addresses 9..15 return 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdAddr | input | 4 | Identifier-mode read word address |
| rdData | output | 16 | Word read at rdAddr (combinational) |
| pgmStrobe | input | 1 | Start a program operation (accepted when not busy) |
| pgmAddr | input | 4 | Program word address |
| pgmData | input | 16 | Program data (bits at 0 clear stored bits) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pgmErr | output | 1 | Program error from last operation |
| lockErr | output | 1 | Lock error from last operation |

## Verification
The bench sweeps all sixteen program addresses and reads back all sixteen read addresses after every operation, comparing each read against an arithmetic model. The sweep would expose a design that wrote the fixed half, let an out-of-range address alias into a real word, or overwrote a word instead of ANDing into it. Each operation is timed cycle by cycle, so an off-by-one busy count or a done pulse longer than one cycle shows up as a timing mismatch. A second strobe is injected mid-operation; a design that restarted or queued that strobe would change a word or pulse done twice. After the lock bit is cleared, the bench tries to program every user word and then programs the lock word again. A design that checked the lock at the wrong time, or let a lock-word write restore the bit, would change the user half or report the wrong flags.

// File: rtl/idreg_pkg.sv
package idreg_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned SEG_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(SEG_WORDS);
  localparam int unsigned LOCK_BIT  = 1;

  localparam logic [ADDR_W-1:0] USER_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = 4'd8;

  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic              wrUser;
    logic              wrLock;
    logic [IDX_W-1:0]  wrIdx;
    logic [WORD_W-1:0] wrData;
  } pgmCmd_t;
endpackage

// File: rtl/idreg_ctrl.sv
module idreg_ctrl
  import idreg_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgmStrobe,
  input  logic [ADDR_W-1:0] pgmAddr,
  input  logic [WORD_W-1:0] pgmData,
  input  logic              userLocked,
  output pgmCmd_t           cmd,
  output logic              busy,
  output logic              done,
  output logic              pgmErr,
  output logic              lockErr
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic {S_IDLE, S_BUSY} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;
  logic              errPQ, errLQ;
  logic              accept, lastCycle;
  logic              classP, classL;

  assign accept    = pgmStrobe && (state == S_IDLE);
  assign lastCycle = (state == S_BUSY) && (cnt == '0);

  // Address and lock classification at acceptance
  always_comb begin
    classP = 1'b0;
    classL = 1'b0;
    if (pgmAddr > LOCK_ADDR) begin
      classP = 1'b1;
    end else if (pgmAddr < USER_BASE) begin
      classP = 1'b1;
      classL = 1'b1;
    end else if (pgmAddr != LOCK_ADDR && userLocked) begin
      classP = 1'b1;
      classL = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
      errPQ   <= 1'b0;
      errLQ   <= 1'b0;
      done    <= 1'b0;
      pgmErr  <= 1'b0;
      lockErr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state   <= S_BUSY;
        cnt     <= CNT_W'(BUSY_CYCLES - 1);
        addrQ   <= pgmAddr;
        dataQ   <= pgmData;
        errPQ   <= classP;
        errLQ   <= classL;
        pgmErr  <= 1'b0;
        lockErr <= 1'b0;
      end else if (lastCycle) begin
        state   <= S_IDLE;
        done    <= 1'b1;
        pgmErr  <= errPQ;
        lockErr <= errLQ;
      end else if (state == S_BUSY) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.wrData = dataQ;
    cmd.wrIdx  = addrQ[IDX_W-1:0];
    if (lastCycle && !errPQ) begin
      cmd.wrLock = (addrQ == LOCK_ADDR);
      cmd.wrUser = (addrQ != LOCK_ADDR);
    end
  end

  assign busy = (state == S_BUSY);

  // R4: done never lasts two cycles
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4: done only follows a busy cycle
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
  // R8: a lock error always comes with a program error
  p_lockerr_implies_pgmerr_r8: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |-> pgmErr);
  // R10: flags hold while idle without a strobe
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !pgmStrobe && !done) |=> ($stable(pgmErr) && $stable(lockErr)));
endmodule

// File: rtl/idreg_store.sv
module idreg_store
  import idreg_pkg::*;
#(
  parameter logic [2*SEG_WORDS*WORD_W/2-1:0] FACTORY_ID = 64'hC3A5_0F1E_7D92_4B68
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgmCmd_t           cmd,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              userLocked
);
  logic [WORD_W-1:0] factWord [SEG_WORDS];
  logic [WORD_W-1:0] userWord [SEG_WORDS];
  logic [WORD_W-1:0] lockWord;

  genvar gi;
  generate
    for (gi = 0; gi < SEG_WORDS; gi++) begin : g_word
      assign factWord[gi] = FACTORY_ID[gi*WORD_W +: WORD_W];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          userWord[gi] <= '1;
        end else if (cmd.wrUser && cmd.wrIdx == IDX_W'(gi)) begin
          userWord[gi] <= userWord[gi] & cmd.wrData;
        end
      end

      // R8: a locked user word never changes
      p_locked_word_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
        userLocked |=> $stable(userWord[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockWord <= '1;
    else if (cmd.wrLock) lockWord <= lockWord & cmd.wrData;
  end

  assign userLocked = !lockWord[LOCK_BIT];

  always_comb begin
    rdData = '0;
    if (rdAddr < USER_BASE)       rdData = factWord[rdAddr[IDX_W-1:0]];
    else if (rdAddr < LOCK_ADDR)  rdData = userWord[rdAddr[IDX_W-1:0]];
    else if (rdAddr == LOCK_ADDR) rdData = lockWord;
  end

  // R8: once locked, stays locked
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    userLocked |=> userLocked);
  // R3: only one kind of write at a time
  p_one_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.wrUser && cmd.wrLock));
  // R8: the control never commits a user write against a locked segment
  p_no_user_write_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrUser |-> !userLocked);
endmodule

// File: rtl/idreg_otp.sv
module idreg_otp
  import idreg_pkg::*;
#(
  parameter logic [63:0] FACTORY_ID  = 64'hC3A5_0F1E_7D92_4B68,
  parameter int unsigned BUSY_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  rdAddr,
  output logic [15:0] rdData,
  input  logic        pgmStrobe,
  input  logic [3:0]  pgmAddr,
  input  logic [15:0] pgmData,
  output logic        busy,
  output logic        done,
  output logic        pgmErr,
  output logic        lockErr
);
  pgmCmd_t cmd;
  logic    userLocked;

  idreg_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pgmStrobe(pgmStrobe), .pgmAddr(pgmAddr),
    .pgmData(pgmData), .userLocked(userLocked), .cmd(cmd), .busy(busy),
    .done(done), .pgmErr(pgmErr), .lockErr(lockErr)
  );

  idreg_store #(.FACTORY_ID(FACTORY_ID)) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdAddr(rdAddr), .rdData(rdData),
    .userLocked(userLocked)
  );
endmodule

// File: tb/idreg_otp_bench.sv
module idreg_otp_bench;
  localparam logic [63:0] FID = 64'hC3A5_0F1E_7D92_4B68;
  localparam int BC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [15:0] rdData;
  logic pgmStrobe = 1'b0;
  logic [3:0] pgmAddr = '0;
  logic [15:0] pgmData = '0;
  logic busy, done, pgmErr, lockErr;

  int nTests = 0;
  int nFail = 0;
  logic [15:0] mdl [16];

  always #4 clk = ~clk;

  idreg_otp #(.FACTORY_ID(FID), .BUSY_CYCLES(BC)) u_idreg_otp (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData),
    .pgmStrobe(pgmStrobe), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .busy(busy), .done(done), .pgmErr(pgmErr), .lockErr(lockErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 16; a++) begin
      rdAddr = 4'(a);
      #1;
      check(req, {16'h0, rdData}, {16'h0, mdl[a]});
    end
  endtask

  // Issue one operation; optional interfering strobe while busy
  task automatic prog(input logic [3:0] a, input logic [15:0] d,
                      input logic eP, input logic eL, input string req,
                      input logic poke);
    int n;
    int dones;
    @(negedge clk);
    pgmAddr = a; pgmData = d; pgmStrobe = 1'b1;
    @(negedge clk);
    pgmStrobe = 1'b0;
    check({req, " R10 flags cleared"}, {30'h0, pgmErr, lockErr}, 32'h0);
    n = 0; dones = 0;
    while (!done && n < 50) begin
      check({req, " R4 busy"}, {31'h0, busy}, 32'h1);
      if (poke && n == 0) begin
        pgmAddr = 4'd5; pgmData = 16'h0000; pgmStrobe = 1'b1;
      end
      @(negedge clk);
      pgmStrobe = 1'b0;
      n++;
    end
    check({req, " R4 busy length"}, n, BC);
    check({req, " R4 busy low at done"}, {31'h0, busy}, 32'h0);
    check({req, " flags"}, {30'h0, pgmErr, lockErr}, {30'h0, eP, eL});
    @(negedge clk);
    check({req, " R4 done single"}, {31'h0, done}, 32'h0);
    check({req, " R10 flags hold"}, {30'h0, pgmErr, lockErr}, {30'h0, eP, eL});
    for (int k = 0; k < 3; k++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check({req, " R5 no extra done"}, dones, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
    for (int i = 0; i < 4; i++) mdl[i] = FID[i*16 +: 16];
    for (int i = 4; i < 9; i++) mdl[i] = 16'hFFFF;

    repeat (3) @(negedge clk);
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 done", {31'h0, done}, 32'h0);
    check("R1 flags", {30'h0, pgmErr, lockErr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readAll("R1/R2/R11 reset read");

    // R3: AND-programming sweep over user words, two passes
    for (int p = 0; p < 2; p++) begin
      for (int w = 4; w < 8; w++) begin
        logic [15:0] d;
        d = 16'hFFFF ^ (16'h1 << (w + p * 5)) ^ (16'h0100 << p);
        prog(4'(w), d, 1'b0, 1'b0, "R3 user write", 1'b0);
        mdl[w] = mdl[w] & d;
        readAll("R3 readback");
      end
    end

    // R5: strobe while busy ignored
    prog(4'd6, 16'hFFF0, 1'b0, 1'b0, "R5 poke", 1'b1);
    mdl[6] = mdl[6] & 16'hFFF0;
    readAll("R5 readback");

    // R7: fixed-half writes rejected
    for (int a = 0; a < 4; a++) begin
      prog(4'(a), 16'h0000, 1'b1, 1'b1, "R7 fixed write", 1'b0);
      readAll("R7 readback");
    end

    // R6: out-of-range writes rejected
    for (int a = 9; a < 16; a++) begin
      prog(4'(a), 16'h0000, 1'b1, 1'b0, "R6 range", 1'b0);
      readAll("R6 readback");
    end

    // R9: lock word bits other than bit 1
    prog(4'd8, 16'hFF7F, 1'b0, 1'b0, "R9 lock word", 1'b0);
    mdl[8] = mdl[8] & 16'hFF7F;
    readAll("R9 readback");
    prog(4'd4, 16'h7FFF, 1'b0, 1'b0, "R8 still unlocked", 1'b0);
    mdl[4] = mdl[4] & 16'h7FFF;
    readAll("R8 unlocked readback");

    // R8: lock the user segment
    prog(4'd8, 16'hFFFD, 1'b0, 1'b0, "R8 set lock", 1'b0);
    mdl[8] = mdl[8] & 16'hFFFD;
    readAll("R8 lock readback");
    for (int w = 4; w < 8; w++) begin
      prog(4'(w), 16'h0000, 1'b1, 1'b1, "R8 locked write", 1'b0);
      readAll("R8 locked readback");
    end
    // R9: lock word still programmable; lock cannot be undone
    prog(4'd8, 16'hFFFF, 1'b0, 1'b0, "R9 relock attempt", 1'b0);
    readAll("R9 lock sticky");
    prog(4'd8, 16'hEFFF, 1'b0, 1'b0, "R9 locked lockword", 1'b0);
    mdl[8] = mdl[8] & 16'hEFFF;
    readAll("R9 readback locked");
    prog(4'd7, 16'h0000, 1'b1, 1'b1, "R8 still locked", 1'b0);
    readAll("R8 final readback");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule